// File: doc/BRIEF.md
# CAS-before-RAS Refresh Scheduler

This block keeps an asynchronous DRAM module refreshed without help from the host. A prescaler and a period counter divide the system clock down to the refresh interval. Each time the interval expires, a refresh is flagged as pending. At the next opportunity the block drives the module's RAS and CAS strobes itself and runs a burst of CAS-before-RAS refresh cycles. CAS is pulled low first. RAS is then pulsed low and high once per refresh cycle while CAS stays low, and CAS is released after the last precharge.

Straight after reset, and before any access may begin, the block issues a series of RAS-only pulses with CAS held high to initialise the DRAM. A host access sequencer shares the strobes. It raises `inhibit_i` to block new bursts, and it treats `busy_o` as "do not touch the strobes". An expiry that arrives while the inhibit is held is not lost: it stays pending and its burst runs as soon as the inhibit drops. Only one overdue burst is ever queued. The burst length, the number of initialisation pulses, the interval (prescaler times ticks, which can be lengthened for slow-refresh parts) and the RAS low and precharge widths in clock cycles are all parameters.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is held, `ras_n_o`=1, `cas_n_o`=1 and `busy_o`=1. Whenever `busy_o` is 0, both strobes are 1.
- R2: Counting clock edges from reset release, the block issues INIT_PULSES RAS-only pulses with `cas_n_o`=1. Each pulse is RAS_HI cycles high followed by RAS_LO cycles low. `busy_o` is 1 throughout and falls after edge INIT_PULSES*(RAS_HI+RAS_LO).
- R3: A burst holds `cas_n_o` low for one cycle with `ras_n_o` high. It then gives BURST_LEN pulses, each RAS_LO cycles low and RAS_HI cycles high, with `cas_n_o` kept low. `cas_n_o` returns high in the cycle after the last high phase.
- R4: A refresh falls due at every edge whose count since reset release is a multiple of PRESCALE*PERIOD_TICKS. If the block is idle and `inhibit_i` is low, `cas_n_o` falls after the next edge.
- R5: No burst starts at an edge where `inhibit_i` is sampled high. A due refresh stays pending, and its burst starts at the first edge that samples `inhibit_i` low.
- R6: However many expiries occur while a burst is held off, releasing the inhibit yields exactly one burst for them. Starting a burst clears the pending flag.
- R7: `busy_o` is 1 from the cycle in which `cas_n_o` falls through the last cycle of the burst, and 0 whenever the block is idle after initialisation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| inhibit_i | input | 1 | Access sequencer blocks the start of a refresh burst |
| ras_n_o | output | 1 | Row strobe to the DRAM, active low |
| cas_n_o | output | 1 | Column strobe to the DRAM, active low |
| busy_o | output | 1 | Initialisation or refresh burst in progress; host must not access |

## Verification
The embedded assertions check on every cycle that CAS falls only while RAS is high and only after an uninhibited pending request. They also check that CAS rises only after a RAS precharge, that starting a burst clears the pending flag, and that timer expiries are never adjacent. The exact pulse counts, the widths of each phase, the position of the first burst relative to reset, the deferral of a burst across two expiries under a long inhibit, and the single resulting burst are shown only by the bench scenarios. In those scenarios a queue-based reference waveform is compared against the strobes on every clock.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
   typedef enum logic [2:0] {
      ST_INIT_HI  = 3'd0,
      ST_INIT_LO  = 3'd1,
      ST_IDLE     = 3'd2,
      ST_CAS_SET  = 3'd3,
      ST_BURST_LO = 3'd4,
      ST_BURST_HI = 3'd5
   } rfs_state_e;
endpackage

// File: rtl/rfs_timer.sv
module rfs_timer #(
   parameter int PRESCALE     = 64,
   parameter int PERIOD_TICKS = 32
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic expire_o
);
   localparam int NW = $clog2(PERIOD_TICKS);

   if (PRESCALE < 1)     begin : g_bad_pre $error("PRESCALE must be at least 1"); end
   if (PERIOD_TICKS < 2) begin : g_bad_per $error("PERIOD_TICKS must be at least 2"); end

   logic tick;

   if (PRESCALE == 1) begin : g_no_pre
      assign tick = 1'b1;
   end else begin : g_pre
      localparam int PW = $clog2(PRESCALE);
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                        pre_q <= '0;
         else if (pre_q == PW'(PRESCALE-1))  pre_q <= '0;
         else                                pre_q <= pre_q + 1'b1;
      end
      assign tick = (pre_q == PW'(PRESCALE-1));
   end

   logic [NW-1:0] per_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) per_q <= '0;
      else if (tick) begin
         if (per_q == NW'(PERIOD_TICKS-1)) per_q <= '0;
         else                              per_q <= per_q + 1'b1;
      end
   end

   assign expire_o = tick && (per_q == NW'(PERIOD_TICKS-1));

   AST_EXPIRE_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire_o |=> !expire_o); // R4
endmodule

// File: rtl/rfs_strobe_fsm.sv
module rfs_strobe_fsm
   import rfs_pkg::*;
#(
   parameter int BURST_LEN   = 256,
   parameter int INIT_PULSES = 8,
   parameter int RAS_LO      = 2,
   parameter int RAS_HI      = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic req_i,
   output logic start_o,
   output logic ras_n_o,
   output logic cas_n_o,
   output logic busy_o
);
   localparam int MAXPH  = (RAS_LO > RAS_HI) ? RAS_LO : RAS_HI;
   localparam int MAXCNT = (BURST_LEN > INIT_PULSES) ? BURST_LEN : INIT_PULSES;
   localparam int PHW    = $clog2(MAXPH + 1);
   localparam int CNW    = $clog2(MAXCNT + 1);

   if (RAS_LO < 1 || RAS_HI < 1) begin : g_bad_ph  $error("RAS phases need at least one cycle"); end
   if (BURST_LEN < 1)            begin : g_bad_bl  $error("BURST_LEN must be at least 1"); end
   if (INIT_PULSES < 1)          begin : g_bad_ini $error("INIT_PULSES must be at least 1"); end

   rfs_state_e     state_q, state_d;
   logic [PHW-1:0] ph_q, ph_d, ph_len;
   logic [CNW-1:0] cnt_q, cnt_d;
   logic           ph_last, low_phase;

   assign low_phase = (state_q == ST_INIT_LO) || (state_q == ST_BURST_LO);
   assign ph_len    = low_phase ? PHW'(RAS_LO) : PHW'(RAS_HI);
   assign ph_last   = (ph_q == ph_len - 1'b1);
   assign start_o   = (state_q == ST_IDLE) && req_i;

   always_comb begin
      state_d = state_q;
      ph_d    = ph_last ? '0 : ph_q + 1'b1;
      cnt_d   = cnt_q;
      unique case (state_q)
         ST_INIT_HI:  if (ph_last) state_d = ST_INIT_LO;
         ST_INIT_LO:  if (ph_last) begin
                         if (cnt_q == CNW'(INIT_PULSES-1)) begin
                            state_d = ST_IDLE;    cnt_d = '0;
                         end else begin
                            state_d = ST_INIT_HI; cnt_d = cnt_q + 1'b1;
                         end
                      end
         ST_IDLE:     begin
                         ph_d = '0;
                         if (req_i) state_d = ST_CAS_SET;
                      end
         ST_CAS_SET:  begin ph_d = '0; state_d = ST_BURST_LO; end
         ST_BURST_LO: if (ph_last) state_d = ST_BURST_HI;
         ST_BURST_HI: if (ph_last) begin
                         if (cnt_q == CNW'(BURST_LEN-1)) begin
                            state_d = ST_IDLE;     cnt_d = '0;
                         end else begin
                            state_d = ST_BURST_LO; cnt_d = cnt_q + 1'b1;
                         end
                      end
         default:     state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_INIT_HI;
         ph_q    <= '0;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         ph_q    <= ph_d;
         cnt_q   <= cnt_d;
      end
   end

   assign ras_n_o = !low_phase;
   assign cas_n_o = !((state_q == ST_CAS_SET) || (state_q == ST_BURST_LO) ||
                      (state_q == ST_BURST_HI));
   assign busy_o  = (state_q != ST_IDLE);

   AST_CAS_BEFORE_RAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(cas_n_o) |-> ras_n_o); // R3
   AST_CAS_AFTER_PRECHARGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cas_n_o) |-> ($past(ras_n_o) && ras_n_o)); // R3
   AST_BUSY_THROUGH_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cas_n_o) |-> $past(busy_o)); // R7
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
   parameter int PRESCALE     = 64,
   parameter int PERIOD_TICKS = 32,
   parameter int BURST_LEN    = 256,
   parameter int INIT_PULSES  = 8,
   parameter int RAS_LO       = 2,
   parameter int RAS_HI       = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic inhibit_i,
   output logic ras_n_o,
   output logic cas_n_o,
   output logic busy_o
);
   localparam longint INTERVAL = longint'(PRESCALE) * PERIOD_TICKS;
   localparam longint BURST_CY = 1 + longint'(BURST_LEN) * (RAS_LO + RAS_HI);

   if (INTERVAL <= BURST_CY) begin : g_bad_interval
      $error("refresh interval must exceed the burst length");
   end

   logic expire, start, pend_q;

   rfs_timer #(.PRESCALE(PRESCALE), .PERIOD_TICKS(PERIOD_TICKS)) u_timer (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .expire_o (expire)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     pend_q <= 1'b0;
      else if (expire) pend_q <= 1'b1;
      else if (start)  pend_q <= 1'b0;
   end

   rfs_strobe_fsm #(
      .BURST_LEN(BURST_LEN), .INIT_PULSES(INIT_PULSES),
      .RAS_LO(RAS_LO), .RAS_HI(RAS_HI)
   ) u_fsm (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (pend_q && !inhibit_i),
      .start_o (start),
      .ras_n_o (ras_n_o),
      .cas_n_o (cas_n_o),
      .busy_o  (busy_o)
   );

   AST_START_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(cas_n_o) |-> ($past(pend_q) && !$past(inhibit_i))); // R5
   AST_PEND_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start && !expire) |=> !pend_q); // R6
   AST_IDLE_HELD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inhibit_i && cas_n_o) |=> cas_n_o); // R5
endmodule

// File: tb/test_dram_refresh_sched.sv
`timescale 1ns/1ps
module test_dram_refresh_sched;
   localparam int PRE = 64, TICKS = 32, BL = 256, NINIT = 8, RLO = 2, RHI = 2;
   localparam int PERIOD = PRE * TICKS;
   localparam int END_EDGE = 19000;

   logic clk = 1'b0, rst_n = 1'b0, inhibit = 1'b0;
   logic ras_n, cas_n, busy;

   always #2.5 clk = ~clk;

   dram_refresh_sched #(.PRESCALE(PRE), .PERIOD_TICKS(TICKS), .BURST_LEN(BL),
      .INIT_PULSES(NINIT), .RAS_LO(RLO), .RAS_HI(RHI)) i_dram_refresh_sched (
      .clk_i(clk), .rst_ni(rst_n), .inhibit_i(inhibit),
      .ras_n_o(ras_n), .cas_n_o(cas_n), .busy_o(busy));

   int tests = 0, fails = 0;
   int ecount = 0;
   bit [2:0] exp_q[$];   // {ras_n, cas_n, busy}
   bit       m_pend = 0;

   // reference model: expected waveform queued per phase
   initial begin
      for (int k = 0; k < NINIT; k++) begin
         for (int c = 0; c < RHI; c++) exp_q.push_back(3'b111);
         for (int c = 0; c < RLO; c++) exp_q.push_back(3'b011);
      end
   end

   always @(posedge clk) begin
      if (rst_n) begin
         bit idle_now, go;
         ecount++;
         idle_now = (exp_q.size() == 0);
         go = idle_now && m_pend && !inhibit;
         if (!idle_now) void'(exp_q.pop_front());
         if (go) begin
            exp_q.push_back(3'b101);
            for (int k = 0; k < BL; k++) begin
               for (int c = 0; c < RLO; c++) exp_q.push_back(3'b001);
               for (int c = 0; c < RHI; c++) exp_q.push_back(3'b101);
            end
         end
         if (ecount % PERIOD == 0) m_pend = 1;
         else if (go)              m_pend = 0;
      end
   end

   task automatic check(input string tag, input int act, input int exp, input string what);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d (edge %0d)", tag, what, act, exp, ecount);
      end
   endtask

   // observations
   bit prev_ras = 1, prev_cas = 1, prev_busy = 1, busy_seen_low = 0;
   int init_falls = 0, busy_low_at = -1, first_cas_fall = -1;
   int burst1_falls = 0, burst1_done = 0, first_burst_on = 0;
   int falls_inh = 0, falls_after = 0, release_fall = -1, short_fall = -1;

   always @(negedge clk) begin
      if (!rst_n) begin
         check("R1", {ras_n, cas_n, busy}, 3'b111, "reset levels");
      end else begin
         bit [2:0] e;
         string tag;
         e = (exp_q.size() != 0) ? exp_q[0] : 3'b110;
         tag = (e[0] == 1'b0) ? "R1" : (e[1] == 1'b1) ? "R2" : "R3";
         check(tag, {ras_n, cas_n}, {e[2], e[1]}, "strobes");
         check("R7", busy, e[0], "busy");
         if (!busy_seen_low && prev_ras && !ras_n && cas_n) init_falls++;
         if (!busy && !busy_seen_low) begin busy_seen_low = 1; busy_low_at = ecount; end
         if (prev_cas && !cas_n) begin
            if (first_cas_fall < 0) begin first_cas_fall = ecount; first_burst_on = 1; end
            if (ecount >= 7000 && ecount < 11500) falls_inh++;
            if (ecount >= 11500 && ecount < 12400) begin
               falls_after++;
               if (release_fall < 0) release_fall = ecount;
            end
            if (ecount >= 16380 && ecount < 16500 && short_fall < 0) short_fall = ecount;
         end
         if (first_burst_on && !burst1_done && prev_ras && !ras_n && !cas_n) burst1_falls++;
         if (first_burst_on && !prev_cas && cas_n) begin first_burst_on = 0; burst1_done = 1; end
         prev_ras = ras_n; prev_cas = cas_n; prev_busy = busy;
      end
   end

   initial begin : watchdog
      #200000;
      fails++;
      tests++;
      $display("FAIL watchdog expired at edge %0d", ecount);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      while (ecount < END_EDGE) begin
         @(negedge clk);
         // long hold-off spans two expiries (8192, 10240); short one spans 16384
         inhibit = (ecount >= 7000 && ecount < 11500) || (ecount >= 16380 && ecount < 16400);
      end
      check("R2", init_falls, NINIT, "RAS-only pulses during init");
      check("R2", busy_low_at, NINIT * (RLO + RHI), "edge at which init ends");
      check("R4", first_cas_fall, PERIOD + 1, "edge of first CAS fall");
      check("R3", burst1_falls, BL, "RAS pulses in one burst");
      check("R5", falls_inh, 0, "bursts started while inhibited");
      check("R5", release_fall, 11501, "edge of deferred burst start");
      check("R6", falls_after, 1, "bursts for two held-off expiries");
      check("R5", short_fall, 16401, "edge of burst after short hold-off");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule